// File: doc/BRIEF.md
# Reset Sequencer with Hard and Software-Requested Resets

This block merges every source of reset in a device into two reset lines for the rest of the chip. Hard resets come from a power-on reset input and from an external active-low reset pin. Software can also request a reset by setting bits in a small control register. The two reset lines are a CPU reset, which restarts only the program-counter path, and a device reset, which returns every register to its default value exactly as a hard reset does.

The block asserts both hard sources at once, without waiting for a clock edge. It releases them in step with the system clock through a chain of flops. Each output stays low for a fixed number of cycles after its cause has gone. When the device reset releases, the CPU reset stays low for a further full hold window, so the CPU starts only after the rest of the device is running.

A four-bit cause register keeps the source of the most recent reset, so that boot code can choose between a cold start and a resume. Only a power-on reset sets it back to the power-on value.

Top module: `reset_ctrl`

## Requirements
- R1: While `por_n` is low, both reset outputs are low without waiting for a clock edge. After `por_n` rises, `ctrl_q` reads 0 and `cause_q` reads 4'b0001.
- R2: A low level on `ext_rst_n`, including a pulse shorter than one clock period, drives both outputs low without waiting for a clock edge. It clears `ctrl_q` and sets `cause_q` to 4'b0010. After a hard source is released, `dev_rst_n` rises on rising edge SYNC_STAGES+HOLD_CYCLES and `cpu_rst_n` rises on edge SYNC_STAGES+2*HOLD_CYCLES, both counted from the release.
- R3: Each reset output stays low for at least HOLD_CYCLES sampled clock edges before it rises.
- R4: A write (`ctrl_we` high at a rising edge) loads `ctrl_wdata` into `ctrl_q`, and bits other than the two request bits keep their value. A write made while `dev_rst_n` is low is dropped.
- R5: Bit 0 of the control register requests a CPU reset. On the next edge `cpu_rst_n` goes low for HOLD_CYCLES edges, `dev_rst_n` stays high, bit 0 clears itself, the other bits are kept, and `cause_q` becomes 4'b0100.
- R6: Bit 1 requests a device reset. On the next edge both outputs go low. `dev_rst_n` stays low for HOLD_CYCLES edges and `cpu_rst_n` for 2*HOLD_CYCLES edges. The whole control register is cleared and `cause_q` becomes 4'b1000.
- R7: When bits 0 and 1 are both set, the device reset takes priority: the result is exactly as in R6.
- R8: `cpu_rst_n` is low on every edge where `dev_rst_n` is low.
- R9: `cause_q` always has exactly one bit set. A device soft reset or a pin reset replaces its value but never restores the power-on value. Only `por_n` does that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | CTRL_W | Control register write data (bit 0 CPU request, bit 1 device request) |
| ctrl_q | output | CTRL_W | Control register contents |
| cause_q | output | 4 | One-hot last reset cause: bit0 power-on, bit1 pin, bit2 CPU soft, bit3 device soft |
| cpu_rst_n | output | 1 | CPU reset, active low |
| dev_rst_n | output | 1 | Device-wide reset, active low |

## Verification
Some properties are checked on every cycle. A low reset pin must hold both outputs low. A device reset must imply a CPU reset. The cause register must stay one-hot. Each request bit must produce its reset on the next edge. The control register must be empty one cycle after the device reset is seen. Each output must also complete a full hold window before it rises. Other behaviour shows only in the bench's scenarios: the exact release edges after a hard source goes away, the pulse lengths of each kind of soft reset, whether the non-request bits survive a CPU reset, writes being dropped during reset, and a reset pin pulse shorter than one clock period still being caught.

// File: rtl/rstc_pkg.sv
// Shared definitions for the reset sequencer: one-hot reset cause codes.
// Assumes a four-entry cause register, one bit per reset source.
package rstc_pkg;
    localparam int CAUSE_W = 4;
    typedef logic [CAUSE_W-1:0] cause_t;

    localparam int CAUSE_IDX_POR = 0;
    localparam int CAUSE_IDX_PIN = 1;
    localparam int CAUSE_IDX_CPU = 2;
    localparam int CAUSE_IDX_DEV = 3;

    localparam cause_t CAUSE_POR = cause_t'(1) << CAUSE_IDX_POR;
    localparam cause_t CAUSE_PIN = cause_t'(1) << CAUSE_IDX_PIN;
    localparam cause_t CAUSE_CPU = cause_t'(1) << CAUSE_IDX_CPU;
    localparam cause_t CAUSE_DEV = cause_t'(1) << CAUSE_IDX_DEV;
endpackage

// File: rtl/rstc_sync.sv
// Reset synchronizer: the output falls as soon as arst_n falls, and rises
// only after STAGES rising clock edges with arst_n high.
// Assumes STAGES >= 2 and that clk runs while the output is released.
module rstc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic sync_n
);
    logic [STAGES-1:0] stg_q;

    // Shift ones in after release; clear the chain at once on assertion.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            stg_q <= '0;
        end else begin
            stg_q <= {stg_q[STAGES-2:0], 1'b1};
        end
    end

    assign sync_n = stg_q[STAGES-1];
endmodule

// File: rtl/rstc_stretch.sv
// Pulse stretcher: active is high while force_n is low, or while load is
// high at a rising edge, and stays high for HOLD more edges after that.
// Assumes force_n is already aligned to clk on release.
module rstc_stretch #(
    parameter int HOLD = 16
) (
    input  logic clk,
    input  logic force_n,
    input  logic load,
    output logic active
);
    localparam int CNT_W = $clog2(HOLD + 1);
    localparam logic [CNT_W-1:0] HOLD_C = CNT_W'(HOLD);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic             act_q;

    // Next count: reload on a request, otherwise count down to zero.
    always_comb begin
        if (load) begin
            cnt_nxt = HOLD_C;
        end else if (cnt_q != '0) begin
            cnt_nxt = cnt_q - 1'b1;
        end else begin
            cnt_nxt = '0;
        end
    end

    // Counter and registered active flag, forced on by the hard source.
    always_ff @(posedge clk or negedge force_n) begin
        if (!force_n) begin
            cnt_q <= HOLD_C;
            act_q <= 1'b1;
        end else begin
            cnt_q <= cnt_nxt;
            act_q <= (cnt_nxt != '0);
        end
    end

    assign active = act_q;
endmodule

// File: rtl/rstc_regs.sv
// Control and cause registers. The control register holds the two soft
// request bits and general bits. The cause register keeps the one-hot
// source of the last reset. Assumes the synchronized hard inputs and the
// device reset output are fed back in.
module rstc_regs
    import rstc_pkg::*;
#(
    parameter int CTRL_W  = 8,
    parameter int CPU_BIT = 0,
    parameter int DEV_BIT = 1
) (
    input  logic              clk,
    input  logic              por_s_n,
    input  logic              pin_s_n,
    input  logic              dev_rst_n,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic [CTRL_W-1:0] ctrl_q,
    output cause_t            cause_q,
    output logic              cpu_fire,
    output logic              dev_fire
);
    // A device request outranks a CPU request when both bits are set.
    assign dev_fire = ctrl_q[DEV_BIT];
    assign cpu_fire = ctrl_q[CPU_BIT] & ~ctrl_q[DEV_BIT];

    // Control register: held clear during device reset, self-clearing requests.
    always_ff @(posedge clk) begin
        if (!dev_rst_n) begin
            ctrl_q <= '0;
        end else if (dev_fire) begin
            ctrl_q <= '0;
        end else if (ctrl_we) begin
            ctrl_q <= ctrl_wdata;
        end else if (cpu_fire) begin
            ctrl_q[CPU_BIT] <= 1'b0;
        end
    end

    // Cause register: power-on first, then pin, device and CPU requests.
    always_ff @(posedge clk) begin
        if (!por_s_n) begin
            cause_q <= CAUSE_POR;
        end else if (!pin_s_n) begin
            cause_q <= CAUSE_PIN;
        end else if (dev_fire) begin
            cause_q <= CAUSE_DEV;
        end else if (cpu_fire) begin
            cause_q <= CAUSE_CPU;
        end
    end
endmodule

// File: rtl/reset_ctrl.sv
// Reset sequencer top. Merges power-on and pin resets with software
// requests into a device reset and a CPU reset. The CPU reset is kept on
// for a full hold window after the device reset ends.
// Assumes clk is running whenever a reset has to be released.
module reset_ctrl
    import rstc_pkg::*;
#(
    parameter int CTRL_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYCLES = 16,
    parameter int CPU_REQ_BIT = 0,
    parameter int DEV_REQ_BIT = 1
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              ext_rst_n,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [3:0]        cause_q,
    output logic              cpu_rst_n,
    output logic              dev_rst_n
);
    localparam int NSRC = 2;

    logic [NSRC-1:0] raw_n;
    logic [NSRC-1:0] sync_n;
    logic            por_s_n;
    logic            pin_s_n;
    logic            hard_n;
    logic            cpu_fire;
    logic            dev_fire;
    logic            dev_act;
    logic            cpu_act;
    cause_t          cause_int;

    assign raw_n = {ext_rst_n, por_n};

    // One synchronizer per hard reset source.
    for (genvar g = 0; g < NSRC; g++) begin : g_sync
        rstc_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .arst_n (raw_n[g]),
            .sync_n (sync_n[g])
        );
    end

    assign por_s_n = sync_n[0];
    assign pin_s_n = sync_n[1];
    assign hard_n  = por_s_n & pin_s_n;

    rstc_regs #(
        .CTRL_W  (CTRL_W),
        .CPU_BIT (CPU_REQ_BIT),
        .DEV_BIT (DEV_REQ_BIT)
    ) u_regs (
        .clk        (clk),
        .por_s_n    (por_s_n),
        .pin_s_n    (pin_s_n),
        .dev_rst_n  (dev_rst_n),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (ctrl_wdata),
        .ctrl_q     (ctrl_q),
        .cause_q    (cause_int),
        .cpu_fire   (cpu_fire),
        .dev_fire   (dev_fire)
    );

    // Device-wide hold window.
    rstc_stretch #(.HOLD(HOLD_CYCLES)) u_dev (
        .clk     (clk),
        .force_n (hard_n),
        .load    (dev_fire),
        .active  (dev_act)
    );

    // CPU hold window, reloaded for as long as the device is in reset.
    rstc_stretch #(.HOLD(HOLD_CYCLES)) u_cpu (
        .clk     (clk),
        .force_n (hard_n),
        .load    (cpu_fire | dev_fire | dev_act),
        .active  (cpu_act)
    );

    assign cause_q   = cause_int;
    assign dev_rst_n = ~dev_act;
    assign cpu_rst_n = ~cpu_act;
endmodule

// File: rtl/rstc_chk.sv
// Property checker for reset_ctrl, bound to every instance. Low-run
// counters stand in for long delay windows.
module rstc_chk #(
    parameter int CTRL_W  = 8,
    parameter int CPU_BIT = 0,
    parameter int DEV_BIT = 1,
    parameter int HOLD    = 16
) (
    input logic              clk,
    input logic              por_n,
    input logic              ext_rst_n,
    input logic [CTRL_W-1:0] ctrl_q,
    input logic [3:0]        cause_q,
    input logic              cpu_rst_n,
    input logic              dev_rst_n
);
    localparam int RUN_W = $clog2(HOLD + 1);
    localparam logic [RUN_W-1:0] HOLD_C = RUN_W'(HOLD);

    logic [RUN_W-1:0] dev_run_q;
    logic [RUN_W-1:0] cpu_run_q;

    // Count sampled low edges of each output, saturating at the hold length.
    always_ff @(posedge clk) begin
        if (!por_n || dev_rst_n) begin
            dev_run_q <= '0;
        end else if (dev_run_q != HOLD_C) begin
            dev_run_q <= dev_run_q + 1'b1;
        end
        if (!por_n || cpu_rst_n) begin
            cpu_run_q <= '0;
        end else if (cpu_run_q != HOLD_C) begin
            cpu_run_q <= cpu_run_q + 1'b1;
        end
    end

    AST_PIN_FORCES_BOTH: assert property (@(posedge clk) disable iff (!por_n)
        !ext_rst_n |-> (!dev_rst_n && !cpu_rst_n)) else $error("pin low, reset released"); // R2

    AST_DEV_MIN_HOLD: assert property (@(posedge clk) disable iff (!por_n)
        $rose(dev_rst_n) |-> (dev_run_q == HOLD_C)) else $error("device reset too short"); // R3

    AST_CPU_MIN_HOLD: assert property (@(posedge clk) disable iff (!por_n)
        $rose(cpu_rst_n) |-> (cpu_run_q == HOLD_C)) else $error("cpu reset too short"); // R3

    AST_CTRL_EMPTY_AFTER_DEV: assert property (@(posedge clk) disable iff (!por_n)
        !dev_rst_n |=> (ctrl_q == '0)) else $error("control kept through device reset"); // R4

    AST_CPU_REQ_FIRES: assert property (@(posedge clk) disable iff (!por_n)
        ctrl_q[CPU_BIT] |=> !cpu_rst_n) else $error("cpu request ignored"); // R5

    AST_DEV_REQ_FIRES: assert property (@(posedge clk) disable iff (!por_n)
        ctrl_q[DEV_BIT] |=> (!dev_rst_n && ctrl_q == '0)) else $error("device request ignored"); // R6

    AST_DEV_IMPLIES_CPU: assert property (@(posedge clk) disable iff (!por_n)
        !dev_rst_n |-> !cpu_rst_n) else $error("cpu out of reset before device"); // R8

    AST_CAUSE_ONEHOT: assert property (@(posedge clk) disable iff (!por_n)
        $onehot(cause_q)) else $error("cause not one-hot"); // R9
endmodule

bind reset_ctrl rstc_chk #(
    .CTRL_W  (CTRL_W),
    .CPU_BIT (CPU_REQ_BIT),
    .DEV_BIT (DEV_REQ_BIT),
    .HOLD    (HOLD_CYCLES)
) u_rstc_chk (
    .clk       (clk),
    .por_n     (por_n),
    .ext_rst_n (ext_rst_n),
    .ctrl_q    (ctrl_q),
    .cause_q   (cause_q),
    .cpu_rst_n (cpu_rst_n),
    .dev_rst_n (dev_rst_n)
);

// File: tb/tb_reset_ctrl.sv
`timescale 1ns/1ps
module tb_reset_ctrl;
    import rstc_pkg::*;

    localparam int W     = 8;
    localparam int SYNC  = 2;
    localparam int HOLD  = 16;
    localparam int CPU_B = 0;
    localparam int DEV_B = 1;
    localparam int WIN   = SYNC + 2*HOLD + 6;

    logic         clk = 1'b0;
    logic         por_n = 1'b1;
    logic         ext_rst_n = 1'b1;
    logic         ctrl_we = 1'b0;
    logic [W-1:0] ctrl_wdata = '0;
    logic [W-1:0] ctrl_q;
    logic [3:0]   cause_q;
    logic         cpu_rst_n;
    logic         dev_rst_n;

    always #2 clk = ~clk;

    reset_ctrl #(
        .CTRL_W(W), .SYNC_STAGES(SYNC), .HOLD_CYCLES(HOLD),
        .CPU_REQ_BIT(CPU_B), .DEV_REQ_BIT(DEV_B)
    ) dut (
        .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_q(ctrl_q),
        .cause_q(cause_q), .cpu_rst_n(cpu_rst_n), .dev_rst_n(dev_rst_n)
    );

    int           n_chk = 0;
    int           n_fail = 0;
    bit           done = 1'b0;
    logic [W-1:0] exp_ctrl = '0;
    logic [3:0]   exp_cause = CAUSE_POR;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected low windows, as first sample index and number of low samples.
    function automatic int hard_dev_len();  return SYNC + HOLD - 1;     endfunction
    function automatic int hard_cpu_len();  return SYNC + 2*HOLD - 1;   endfunction
    function automatic int soft_dev_len();  return HOLD;                endfunction
    function automatic int soft_cpu_len(input bit dev); return dev ? 2*HOLD : HOLD; endfunction

    // Outcome of a register write per R4..R7.
    function automatic void predict_write(input logic [W-1:0] d, output int dl, output int cl,
                                          output logic [W-1:0] nc, output logic [3:0] ncause);
        if (d[DEV_B]) begin
            dl = soft_dev_len(); cl = soft_cpu_len(1'b1); nc = '0; ncause = CAUSE_DEV;
        end else if (d[CPU_B]) begin
            dl = 0; cl = soft_cpu_len(1'b0); nc = d & ~(W'(1) << CPU_B); ncause = CAUSE_CPU;
        end else begin
            dl = 0; cl = 0; nc = d; ncause = exp_cause;
        end
    endfunction

    // Sample both outputs after each of the next WIN rising edges.
    task automatic measure(output int ds, output int dl, output int cs, output int cl);
        ds = -1; dl = 0; cs = -1; cl = 0;
        for (int k = 0; k < WIN; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (!dev_rst_n) begin if (ds < 0) ds = k; dl++; end
            if (!cpu_rst_n) begin if (cs < 0) cs = k; cl++; end
        end
    endtask

    task automatic check_windows(input string rd, input string rc, input int dl_e, input int cl_e);
        int ds, dl, cs, cl;
        measure(ds, dl, cs, cl);
        chk(rd, "device low samples", dl, dl_e);
        if (dl_e > 0) chk(rd, "device first low sample", ds, 0);
        chk(rc, "cpu low samples", cl, cl_e);
        if (cl_e > 0) chk(rc, "cpu first low sample", cs, 0);
        chk(rd, "ctrl after", int'(ctrl_q), int'(exp_ctrl));
        chk("R9", "cause after", int'(cause_q), int'(exp_cause));
    endtask

    task automatic do_write(input logic [W-1:0] d, input string rd, input string rc);
        int dl, cl;
        logic [W-1:0] nc;
        logic [3:0] ncause;
        predict_write(d, dl, cl, nc, ncause);
        @(negedge clk);
        ctrl_we = 1'b1; ctrl_wdata = d;
        @(posedge clk);
        #1 ctrl_we = 1'b0;
        exp_ctrl = nc; exp_cause = ncause;
        check_windows(rd, rc, dl, cl);
    endtask

    // Pin pulse of len cycles, or shorter than one cycle when len is 0.
    task automatic do_pin(input int len, input bit wr_during);
        @(negedge clk);
        if (len == 0) begin
            #0.5 ext_rst_n = 1'b0;
            #0.5 chk("R2", "glitch forces device reset", int'(dev_rst_n), 0);
            chk("R2", "glitch forces cpu reset", int'(cpu_rst_n), 0);
            ext_rst_n = 1'b1;
        end else begin
            ext_rst_n = 1'b0;
            #1 chk("R2", "pin forces device reset", int'(dev_rst_n), 0);
            chk("R2", "pin forces cpu reset", int'(cpu_rst_n), 0);
            if (wr_during) begin
                ctrl_wdata = '1; ctrl_we = 1'b1;
                @(posedge clk);
                #1 ctrl_we = 1'b0;
            end
            repeat (len) @(negedge clk);
            ext_rst_n = 1'b1;
        end
        exp_ctrl = '0; exp_cause = CAUSE_PIN;
        check_windows("R2", "R8", hard_dev_len(), hard_cpu_len());
    endtask

    task automatic do_por();
        @(negedge clk);
        por_n = 1'b0;
        #1 chk("R1", "por forces device reset", int'(dev_rst_n), 0);
        chk("R1", "por forces cpu reset", int'(cpu_rst_n), 0);
        repeat (3) @(negedge clk);
        chk("R1", "cause during por", int'(cause_q), int'(CAUSE_POR));
        chk("R1", "ctrl during por", int'(ctrl_q), 0);
        por_n = 1'b1;
        exp_ctrl = '0; exp_cause = CAUSE_POR;
        check_windows("R1", "R3", hard_dev_len(), hard_cpu_len());
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        #1 por_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1", "reset state device", int'(dev_rst_n), 0);
        chk("R1", "reset state cpu", int'(cpu_rst_n), 0);
        chk("R1", "reset state cause", int'(cause_q), int'(CAUSE_POR));
        por_n = 1'b1;
        check_windows("R1", "R3", hard_dev_len(), hard_cpu_len());

        do_write(8'hA4, "R4", "R4");             // plain bits, no reset
        do_write(8'hA5, "R5", "R5");             // CPU request keeps other bits
        do_write(8'hA2, "R6", "R8");             // device request clears all
        do_write(8'h5C, "R4", "R4");
        do_write(8'h03, "R7", "R7");             // both bits: device wins
        do_write(8'h30, "R4", "R4");
        do_pin(3, 1'b1);                         // R2, R4: write during reset dropped
        do_pin(0, 1'b0);                         // R2: sub-cycle pulse
        do_write(8'h81, "R5", "R3");

        for (int i = 0; i < 40; i++) begin
            int op;
            op = int'($urandom_range(3, 0));
            if (op == 2) begin
                do_pin(int'($urandom_range(4, 1)), 1'($urandom_range(1, 0)));
            end else if (op == 3) begin
                do_write(W'($urandom) | W'(3), "R7", "R8");
            end else begin
                do_write(W'($urandom), "R5", "R6");
            end
        end

        do_write(8'h40, "R4", "R4");
        do_por();                                // R9: only POR restores POR cause

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule